// File: doc/BRIEF.md
# Control-Frame Statistics Counter Bank

This block keeps six wide event counters that tally valid MAC control frames, split by class (multicast, broadcast, priority flow control) and by direction (receive and transmit). Each direction presents a one-cycle frame strobe with a validity flag and a two-bit class code. A strobe that is flagged valid and carries a counted class adds exactly one to the matching counter. All counters live in flip-flops and can be read but never written.

Software reads the counters over a narrow register port whose data word is narrower than a counter. Each counter therefore occupies two word addresses: one for the low word and one for the remaining upper bits. The low word must be read first. That read copies the counter's upper bits into a shadow register, and the following upper-word read returns the shadow. The two halves are then taken from the same instant, even if the counter moves between the two reads. Read data appears one clock after the read strobe.

With the default parameters the port is 32 bits wide, the counters are 36 bits wide and the address is 4 bits wide. Bench runs use a smaller configuration so that carries and wrap-around can be reached.

Top module: `ctlfrm_stat_bank`

## Requirements
- R1: After synchronous reset every counter, the shadow register and `rd_data` are zero.
- R2: A cycle with strobe high, valid high and class code 0 (multicast), 1 (broadcast) or 2 (priority flow control) adds exactly one to that direction's counter of that class. Class code 3, valid low or strobe low leaves every counter unchanged.
- R3: Receive and transmit events are independent and may arrive in the same cycle. Each increments only its own direction's counter.
- R4: Counter index k is 3*dir + class, where dir 0 is receive and dir 1 is transmit. Word address 2k returns counter bits [DATA_W-1:0]. Word address 2k+1 returns the upper CNT_W-DATA_W bits, zero-extended.
- R5: A low-word read copies the counter's upper bits into the shadow register. A high-word read returns the shadow, so the pair is coherent even if the counter changes between the two reads.
- R6: When a low-word read and an increment of the same counter happen in the same cycle, both the returned low word and the captured upper bits are the value before the increment.
- R7: A counter at its all-ones value returns to zero on the next increment.
- R8: Word addresses from 2*6 upward return zero and leave the shadow register unchanged.
- R9: `rd_data` is valid exactly one clock after `rd_en` and is zero in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_strobe | input | 1 | Receive frame event |
| rx_good | input | 1 | Receive frame is valid |
| rx_class | input | 2 | Receive class code (0 mcast, 1 bcast, 2 pfc, 3 none) |
| tx_strobe | input | 1 | Transmit frame event |
| tx_good | input | 1 | Transmit frame is valid |
| tx_class | input | 2 | Transmit class code (0 mcast, 1 bcast, 2 pfc, 3 none) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (4) | Word address |
| rd_data | output | DATA_W (32) | Read data, one clock after `rd_en` |

## Verification
On every cycle, the assertions check the following:
- each counter steps by exactly one when told to and holds otherwise;
- a counter wraps from all-ones to zero;
- at most one counter per direction moves;
- the upper bits of a high-word read are zero;
- reserved addresses return zero;
- the shadow register changes only on a low-word read;
- the data is zero after a cycle with no read.

Only the bench scenarios can show the following:
- that the right counter is tied to each address;
- that a high-word read returns bits captured earlier even when the counter has since carried into its upper part;
- that a read and an increment in the same cycle return the pre-increment value.

// File: rtl/ctlfrm_stat_pkg.sv
package ctlfrm_stat_pkg;

    localparam int NUM_DIRS    = 2;
    localparam int NUM_CLASSES = 3;
    localparam int NUM_CTRS    = NUM_DIRS * NUM_CLASSES;

    typedef enum logic [1:0] {
        FC_MCAST = 2'd0,
        FC_BCAST = 2'd1,
        FC_PFC   = 2'd2,
        FC_NONE  = 2'd3
    } frame_class_e;

    typedef struct packed {
        logic         strobe;
        logic         good;
        frame_class_e cls;
    } frame_evt_t;

    function automatic int ctr_index(input int dir, input int cls);
        return dir * NUM_CLASSES + cls;
    endfunction

endpackage

// File: rtl/ctlfrm_evt_decode.sv
module ctlfrm_evt_decode
    import ctlfrm_stat_pkg::*;
(
    input  frame_evt_t             evt,
    output logic [NUM_CLASSES-1:0] inc
);
    always_comb begin
        inc = '0;
        if (evt.strobe && evt.good) begin
            for (int c = 0; c < NUM_CLASSES; c++) begin
                if (evt.cls == frame_class_e'(c)) inc[c] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctlfrm_counter.sv
module ctlfrm_counter #(
    parameter int CNT_W = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        inc && !(&count) |=> count == $past(count) + CNT_W'(1));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count));
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        inc && (&count) |=> count == '0);
endmodule

// File: rtl/ctlfrm_readout.sv
module ctlfrm_readout
    import ctlfrm_stat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 36,
    parameter int ADDR_W = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [NUM_CTRS-1:0][CNT_W-1:0]  counts,
    output logic [DATA_W-1:0]               rd_data
);
    localparam int HI_W  = CNT_W - DATA_W;
    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0] idx;
    logic             hi_sel;
    logic             hit;
    logic [CNT_W-1:0] sel;
    logic [HI_W-1:0]  shadow;

    assign idx    = rd_addr[ADDR_W-1:1];
    assign hi_sel = rd_addr[0];

    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = 0; i < NUM_CTRS; i++) begin
            if (idx == IDX_W'(i)) begin
                hit = 1'b1;
                sel = counts[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            rd_data <= '0;
        end else begin
            rd_data <= '0;
            if (rd_en && hit) begin
                if (hi_sel) begin
                    rd_data <= DATA_W'(shadow);
                end else begin
                    rd_data <= sel[DATA_W-1:0];
                    shadow  <= sel[CNT_W-1:DATA_W];
                end
            end
        end
    end

    p_hi_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr[0] |=> rd_data[DATA_W-1:HI_W] == '0);
    p_hi_from_shadow_r5: assert property (@(posedge clk) disable iff (rst)
        rd_en && hit && rd_addr[0] |=> rd_data == DATA_W'($past(shadow)));
    p_shadow_only_low_r5: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && !rd_addr[0]) |=> $stable(shadow));
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
        rd_en && (rd_addr >= ADDR_W'(2 * NUM_CTRS)) |=> rd_data == '0);
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);
endmodule

// File: rtl/ctlfrm_stat_bank.sv
module ctlfrm_stat_bank
    import ctlfrm_stat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 36,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_strobe,
    input  logic              rx_good,
    input  logic [1:0]        rx_class,
    input  logic              tx_strobe,
    input  logic              tx_good,
    input  logic [1:0]        tx_class,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    frame_evt_t                          evts [NUM_DIRS];
    logic [NUM_DIRS-1:0][NUM_CLASSES-1:0] inc;
    logic [NUM_CTRS-1:0][CNT_W-1:0]       counts;

    assign evts[0] = '{strobe: rx_strobe, good: rx_good, cls: frame_class_e'(rx_class)};
    assign evts[1] = '{strobe: tx_strobe, good: tx_good, cls: frame_class_e'(tx_class)};

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
        ctlfrm_evt_decode u_dec (
            .evt (evts[d]),
            .inc (inc[d])
        );
        for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
            ctlfrm_counter #(.CNT_W(CNT_W)) u_ctr (
                .clk   (clk),
                .rst   (rst),
                .inc   (inc[d][c]),
                .count (counts[ctr_index(d, c)])
            );
        end
        p_one_per_dir_r2: assert property (@(posedge clk) disable iff (rst)
            $onehot0(inc[d]));
    end

    ctlfrm_readout #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .counts  (counts),
        .rd_data (rd_data)
    );

    p_bad_class_r2: assert property (@(posedge clk) disable iff (rst)
        !(rx_strobe && rx_good && rx_class != 2'd3) |-> inc[0] == '0);
endmodule

// File: tb/ctlfrm_stat_bank_bench.sv
module ctlfrm_stat_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CW = 12;
    localparam int AW = 4;
    localparam int CMASK = (1 << CW) - 1;
    localparam int LMASK = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_strobe = 0, rx_good = 0, tx_strobe = 0, tx_good = 0, rd_en = 0;
    logic [1:0] rx_class = 0, tx_class = 0;
    logic [AW-1:0] rd_addr = 0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int model [6];
    int got;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlfrm_stat_bank #(.DATA_W(DW), .CNT_W(CW), .ADDR_W(AW)) u_ctlfrm_stat_bank (
        .clk(clk), .rst(rst),
        .rx_strobe(rx_strobe), .rx_good(rx_good), .rx_class(rx_class),
        .tx_strobe(tx_strobe), .tx_good(tx_good), .tx_class(tx_class),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: inputs applied at a falling edge, result taken at the next one.
    task automatic cyc(input bit re, input int addr,
                       input bit rs, input bit rg, input int rc,
                       input bit ts, input bit tg, input int tc,
                       output int data);
        rd_en = re; rd_addr = AW'(addr);
        rx_strobe = rs; rx_good = rg; rx_class = 2'(rc);
        tx_strobe = ts; tx_good = tg; tx_class = 2'(tc);
        @(negedge clk);
        data = int'(rd_data);
        if (rs && rg && rc < 3) model[rc]     = (model[rc] + 1) & CMASK;
        if (ts && tg && tc < 3) model[3 + tc] = (model[3 + tc] + 1) & CMASK;
        rd_en = 0; rx_strobe = 0; tx_strobe = 0;
    endtask

    task automatic rd(input int addr, output int data);
        cyc(1, addr, 0, 0, 0, 0, 0, 0, data);
    endtask

    task automatic bump(input int k);
        int d;
        if (k < 3) cyc(0, 0, 1, 1, k, 0, 0, 0, d);
        else       cyc(0, 0, 0, 0, 0, 1, 1, k - 3, d);
    endtask

    task automatic check_ctr(input string req, input int k);
        int d;
        rd(2 * k, d);     check(req, d, model[k] & LMASK);
        rd(2 * k + 1, d); check(req, d, model[k] >> DW);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        check("R1 rd_data", int'(rd_data), 0);
        rst = 0;
        @(negedge clk);
        for (int k = 0; k < 6; k++) check_ctr("R1", k);

        // R2 R3 R4: sweep every class pair, valid pair and strobe pair
        for (int rc = 0; rc < 4; rc++) begin
            for (int tc = 0; tc < 4; tc++) begin
                for (int g = 0; g < 4; g++) begin
                    for (int s = 0; s < 4; s++) begin
                        cyc(0, 0, s[0], g[0], rc, s[1], g[1], tc, got);
                    end
                end
            end
            for (int k = 0; k < 6; k++) check_ctr("R2 R3 R4", k);
        end
        // extra weighting so counters differ
        for (int k = 0; k < 6; k++)
            for (int n = 0; n <= k * 7; n++) bump(k);
        for (int k = 0; k < 6; k++) check_ctr("R4", k);

        // R9: idle cycle after a read yields zero
        rd(0, got);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, got);
        check("R9 idle", got, 0);

        // R5: coherent snapshot across a carry into the upper part
        while (model[4] != 250) bump(4);
        rd(8, got); check("R5 low", got, 250);
        for (int n = 0; n < 10; n++) bump(4);
        rd(9, got); check("R5 high shadow", got, 0);
        check_ctr("R5 after carry", 4);

        // R8: reserved addresses read zero and leave the shadow alone
        for (int a = 12; a < 16; a++) begin
            rd(a, got); check("R8 reserved", got, 0);
        end
        rd(9, got); check("R8 shadow kept", got, 1);

        // R6: read and increment in the same cycle
        while (model[2] != 511) bump(2);
        cyc(1, 4, 1, 1, 2, 0, 0, 0, got);
        check("R6 low pre-inc", got, 255);
        rd(5, got); check("R6 high pre-inc", got, 1);
        check_ctr("R6 after", 2);

        // R7: wrap to zero
        while (model[0] != CMASK) bump(0);
        check_ctr("R7 all ones", 0);
        bump(0);
        check_ctr("R7 wrapped", 0);
        check("R7 model", model[0], 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule